// File: doc/BRIEF.md
# Exception entry and vectoring unit

This unit sits beside the fetch stage of a small processor whose 26-bit program counter lives in one 32-bit word along with the mode and the interrupt-mask bits. Each cycle it gathers the exception request strobes, the two interrupt requests and a check on the current fetch address. A fetch address at or above the top of the 26-bit space counts as an address exception, and this includes the address reached by the normal +4 step from the last word. The unit then picks the single most urgent pending source.

On the clock edge after a request, the unit pulses a flush. In the same cycle it drives the fixed vector address to fetch from, the new combined status word for the handler, the link word to save, and the index of the vector taken. The link word packs the return offset (exception address plus 8, truncated to the 26-bit field) together with the mode and mask bits exactly as they stood before entry.

All of these pins are plain control signals with no handshake. Every cycle either takes one vector or takes none. The outputs keep their last values between entries.

Top module: `exc_entry`

## Requirements
- R1: Vector indices are reset 0, undefined instruction 1, software interrupt 2, prefetch abort 3, data abort 4, address exception 5, IRQ 6, FIRQ 7. On entry, `fetch_o` equals the index times 4, and `cause_o` equals the index, one clock after the request cycle.
- R2: An address exception is pending when `fetch_valid` is high and `fetch_addr` is 0x4000000 or above, that is when any of bits 31:26 is set. The address 0x3FFFFFC raises nothing.
- R3: `link_o` bits 25:2 hold bits 25:2 of (exception address + 8). The exception address is `fetch_addr` for an address exception; for every other source it is `psr_i & 0x03FFFFFC`. Bits 31:26 and 1:0 of `link_o` equal those bits of `psr_i` in the request cycle.
- R4: When several sources are pending together, the winner is chosen in this order, highest first: reset, data abort, FIRQ, IRQ, address exception, prefetch abort, undefined instruction, software interrupt. Only one vector is taken per entry.
- R5: In `new_psr_o`, bits 1:0 are 2'b11 (supervisor) and bit 27 (the IRQ mask) is 1. Bit 26 (the FIRQ mask) is 1 for reset and FIRQ, and otherwise keeps its old value. Bits 31:28 are copied from the old word, and bits 25:2 hold the vector index.
- R6: `irq_req` is ignored while `psr_i` bit 27 is 1. `firq_req` is ignored while `psr_i` bit 26 is 1.
- R7: `flush_o` is high for exactly the one cycle following each cycle with a pending source. In a cycle with no pending source, `flush_o` is low and the other outputs keep their values.
- R8: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_rst | input | 1 | reset exception strobe |
| req_und | input | 1 | undefined instruction strobe |
| req_swi | input | 1 | software interrupt strobe |
| req_pabt | input | 1 | prefetch abort strobe |
| req_dabt | input | 1 | data abort strobe |
| irq_req | input | 1 | normal interrupt request |
| firq_req | input | 1 | fast interrupt request |
| fetch_valid | input | 1 | fetch_addr is a live sequential fetch |
| fetch_addr | input | 32 | current fetch byte address, unbounded |
| psr_i | input | 32 | current combined PC/status word |
| flush_o | output | 1 | one-cycle pipeline flush / redirect strobe |
| fetch_o | output | 32 | redirected fetch address (vector) |
| new_psr_o | output | 32 | combined word for the handler |
| link_o | output | 32 | word to write to the link register |
| cause_o | output | 3 | index of the vector taken |

## Verification
Every result sits behind one register stage. The flush, the vector, the new status word, the link word and the cause are all due on the first rising edge after the cycle in which the inputs were applied. The driver sets the inputs just after a falling edge and pushes exactly one expected item per driven cycle. The monitor samples just after the following rising edge and pops one item there. Idle and masked cycles push an item that expects no flush and unchanged outputs, so a result that comes a cycle early or late, or that is stray, shows up as a mismatch.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NVEC = 8;
  localparam int IDXW = $clog2(NVEC);

  typedef enum logic [IDXW-1:0] {
    V_RST  = 3'd0,
    V_UND  = 3'd1,
    V_SWI  = 3'd2,
    V_PABT = 3'd3,
    V_DABT = 3'd4,
    V_ADDR = 3'd5,
    V_IRQ  = 3'd6,
    V_FIRQ = 3'd7
  } vec_e;

  // rank 0 is most urgent
  function automatic vec_e rank_vec(input int rank);
    case (rank)
      0:       return V_RST;
      1:       return V_DABT;
      2:       return V_FIRQ;
      3:       return V_IRQ;
      4:       return V_ADDR;
      5:       return V_PABT;
      6:       return V_UND;
      default: return V_SWI;
    endcase
  endfunction
endpackage

// File: rtl/exc_range.sv
module exc_range #(
  parameter int XLEN = 32,
  parameter int AW   = 26
) (
  input  logic                 valid,
  input  logic [XLEN-AW-1:0]   addr_hi,
  output logic                 over
);
  // any bit above the addressable field means the fetch left the space
  assign over = valid && (addr_hi != '0);
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic [NVEC-1:0] pend,
  output logic            any,
  output vec_e            sel
);
  always_comb begin
    any = 1'b0;
    sel = V_RST;
    for (int r = NVEC - 1; r >= 0; r--) begin
      if (pend[int'(rank_vec(r))]) begin
        any = 1'b1;
        sel = rank_vec(r);
      end
    end
  end
endmodule

// File: rtl/exc_word.sv
module exc_word
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int AW    = 26,
  parameter int MODEW = 2
) (
  input  logic [XLEN-1:0] psr,
  input  logic [XLEN-1:0] fetch_addr,
  input  vec_e            sel,
  output logic [XLEN-1:0] link,
  output logic [XLEN-1:0] new_psr,
  output logic [XLEN-1:0] vec_addr
);
  localparam int PCW      = AW - MODEW;
  localparam int FIRQ_BIT = AW;
  localparam logic [1:0] SUPER = 2'b11;

  logic [XLEN-1:0] exc_addr;
  logic [XLEN-1:0] ret_addr;
  logic            firq_mask;

  always_comb begin
    if (sel == V_ADDR)
      exc_addr = fetch_addr;
    else
      exc_addr = {{(XLEN-AW){1'b0}}, psr[AW-1:MODEW], {MODEW{1'b0}}};
    ret_addr  = exc_addr + XLEN'(8);
    firq_mask = psr[FIRQ_BIT] | (sel == V_RST) | (sel == V_FIRQ);
  end

  assign link     = {psr[XLEN-1:AW], ret_addr[AW-1:MODEW], psr[MODEW-1:0]};
  assign new_psr  = {psr[XLEN-1:AW+2], 1'b1, firq_mask, PCW'(sel), SUPER};
  assign vec_addr = {{(XLEN-IDXW-2){1'b0}}, sel, 2'b00};
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_rst,
  input  logic            req_und,
  input  logic            req_swi,
  input  logic            req_pabt,
  input  logic            req_dabt,
  input  logic            irq_req,
  input  logic            firq_req,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_addr,
  input  logic [XLEN-1:0] psr_i,
  output logic            flush_o,
  output logic [XLEN-1:0] fetch_o,
  output logic [XLEN-1:0] new_psr_o,
  output logic [XLEN-1:0] link_o,
  output logic [IDXW-1:0] cause_o
);
  localparam int IRQ_BIT  = AW + 1;
  localparam int FIRQ_BIT = AW;

  logic            addr_over;
  logic [NVEC-1:0] pend;
  logic            any;
  vec_e            sel;
  logic [XLEN-1:0] link_n, psr_n, vec_n;

  exc_range #(.XLEN(XLEN), .AW(AW)) u_range (
    .valid   (fetch_valid),
    .addr_hi (fetch_addr[XLEN-1:AW]),
    .over    (addr_over)
  );

  always_comb begin
    pend         = '0;
    pend[V_RST]  = req_rst;
    pend[V_UND]  = req_und;
    pend[V_SWI]  = req_swi;
    pend[V_PABT] = req_pabt;
    pend[V_DABT] = req_dabt;
    pend[V_ADDR] = addr_over;
    pend[V_IRQ]  = irq_req  & ~psr_i[IRQ_BIT];
    pend[V_FIRQ] = firq_req & ~psr_i[FIRQ_BIT];
  end

  exc_prio u_prio (.pend(pend), .any(any), .sel(sel));

  exc_word #(.XLEN(XLEN), .AW(AW)) u_word (
    .psr        (psr_i),
    .fetch_addr (fetch_addr),
    .sel        (sel),
    .link       (link_n),
    .new_psr    (psr_n),
    .vec_addr   (vec_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_o   <= 1'b0;
      fetch_o   <= '0;
      new_psr_o <= '0;
      link_o    <= '0;
      cause_o   <= '0;
    end else begin
      flush_o <= any;
      if (any) begin
        fetch_o   <= vec_n;
        new_psr_o <= psr_n;
        link_o    <= link_n;
        cause_o   <= sel;
      end
    end
  end

  p_vec_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> fetch_o == {{(XLEN-IDXW-2){1'b0}}, cause_o, 2'b00});

  p_addr_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && cause_o == V_ADDR) |->
      ($past(fetch_valid) && $past(fetch_addr[XLEN-1:AW]) != '0));

  p_link_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (link_o[XLEN-1:AW] == $past(psr_i[XLEN-1:AW]) &&
                 link_o[1:0] == $past(psr_i[1:0])));

  p_rst_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_rst |=> (flush_o && cause_o == V_RST));

  p_super_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (new_psr_o[1:0] == 2'b11 && new_psr_o[IRQ_BIT]));

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && psr_i[IRQ_BIT] && !(req_rst || req_und || req_swi ||
      req_pabt || req_dabt || firq_req || fetch_valid)) |=> !flush_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_o |-> ($stable(link_o) && $stable(new_psr_o) && $stable(fetch_o)));
endmodule

// File: tb/test_exc_entry.sv
module test_exc_entry;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        fl;
    logic [31:0] fa;
    logic [31:0] np;
    logic [31:0] lk;
    logic [2:0]  c;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_rst = 0, req_und = 0, req_swi = 0, req_pabt = 0, req_dabt = 0;
  logic        irq_req = 0, firq_req = 0, fetch_valid = 0;
  logic [31:0] fetch_addr = '0, psr_i = '0;
  logic        flush_o;
  logic [31:0] fetch_o, new_psr_o, link_o;
  logic [2:0]  cause_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  item_t q[$];
  item_t last;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry i_exc_entry (
    .clk(clk), .rst_n(rst_n), .req_rst(req_rst), .req_und(req_und),
    .req_swi(req_swi), .req_pabt(req_pabt), .req_dabt(req_dabt),
    .irq_req(irq_req), .firq_req(firq_req), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .psr_i(psr_i), .flush_o(flush_o),
    .fetch_o(fetch_o), .new_psr_o(new_psr_o), .link_o(link_o),
    .cause_o(cause_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // rq bit order: 0 rst 1 und 2 swi 3 pabt 4 dabt 6 irq 7 firq
  task automatic drive(string tag, logic [7:0] rq, logic fv,
                       logic [31:0] fa, logic [31:0] psr);
    item_t e;
    int idx;
    logic [31:0] ex;
    logic irq_ok, firq_ok, aex;
    @(negedge clk);
    req_rst = rq[0]; req_und = rq[1]; req_swi = rq[2]; req_pabt = rq[3];
    req_dabt = rq[4]; irq_req = rq[6]; firq_req = rq[7];
    fetch_valid = fv; fetch_addr = fa; psr_i = psr;
    irq_ok  = rq[6] && !psr[27];
    firq_ok = rq[7] && !psr[26];
    aex     = fv && (fa >= 32'h0400_0000);
    if (rq[0]) idx = 0;
    else if (rq[4]) idx = 4;
    else if (firq_ok) idx = 7;
    else if (irq_ok) idx = 6;
    else if (aex) idx = 5;
    else if (rq[3]) idx = 3;
    else if (rq[1]) idx = 1;
    else if (rq[2]) idx = 2;
    else idx = -1;
    e = last;
    e.tag = tag;
    if (idx < 0) e.fl = 1'b0;
    else begin
      e.fl = 1'b1;
      e.c  = 3'(idx);
      e.fa = 32'(idx) << 2;
      ex   = (idx == 5) ? fa : (psr & 32'h03FF_FFFC);
      e.lk = (psr & 32'hFC00_0003) | ((ex + 32'd8) & 32'h03FF_FFFC);
      e.np = (psr & 32'hF000_0000) | 32'h0800_0000 |
             ({31'd0, psr[26] | idx == 0 | idx == 7} << 26) |
             (32'(idx) << 2) | 32'd3;
      last = e;
    end
    q.push_back(e);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      check({e.tag, " flush"}, {31'd0, flush_o}, {31'd0, e.fl});
      check({e.tag, " fetch"}, fetch_o, e.fa);
      check({e.tag, " newpsr"}, new_psr_o, e.np);
      check({e.tag, " link"}, link_o, e.lk);
      check({e.tag, " cause"}, {29'd0, cause_o}, {29'd0, e.c});
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    last = '{fl: 1'b0, fa: '0, np: '0, lk: '0, c: '0, tag: ""};
    repeat (2) @(posedge clk);
    #1;
    // R8 reset state
    check("R8 flush", {31'd0, flush_o}, 32'd0);
    check("R8 fetch", fetch_o, 32'd0);
    check("R8 newpsr", new_psr_o, 32'd0);
    check("R8 link", link_o, 32'd0);
    check("R8 cause", {29'd0, cause_o}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R5 each source alone
    drive("R1 und",  8'h02, 0, 32'h100, 32'h0000_1000);
    drive("R1 swi",  8'h04, 0, 32'h100, 32'h8000_2000);
    drive("R1 pabt", 8'h08, 0, 32'h100, 32'h0400_0040);
    drive("R1 dabt", 8'h10, 0, 32'h100, 32'h0000_0400);
    drive("R5 irq",  8'h40, 0, 32'h100, 32'h4000_0010);
    drive("R5 firq", 8'h80, 0, 32'h100, 32'h2000_0010);
    drive("R5 rst",  8'h01, 0, 32'h100, 32'h0000_0000);
    // R7 idle cycle keeps outputs
    drive("R7 idle", 8'h00, 0, 32'h100, 32'h0000_0000);
    // R2 address exception at the boundary, masks set in user mode
    drive("R2 boundary", 8'h00, 1, 32'h0400_0000, 32'h0C00_0000);
    drive("R2 below", 8'h00, 1, 32'h03FF_FFFC, 32'h0000_0000);
    drive("R2 invalid", 8'h00, 0, 32'h0800_0000, 32'h0000_0000);
    drive("R2 high", 8'h00, 1, 32'hF000_0004, 32'h0000_0001);
    // R3 return offset wraps inside the 26-bit field
    drive("R3 wrap", 8'h02, 0, 32'h0, 32'hFBFF_FFFE);
    // R6 masked interrupts
    drive("R6 irq masked", 8'h40, 0, 32'h0, 32'h0800_0000);
    drive("R6 firq masked", 8'h80, 0, 32'h0, 32'h0400_0000);
    drive("R6 irq pass firq masked", 8'hC0, 0, 32'h0, 32'h0400_0000);
    // R4 priority pairs
    drive("R4 all", 8'hDF, 1, 32'h0400_0000, 32'h0);
    drive("R4 dabt>firq", 8'h90, 0, 32'h0, 32'h0);
    drive("R4 firq>irq", 8'hC0, 0, 32'h0, 32'h0);
    drive("R4 irq>addr", 8'h40, 1, 32'h0400_0000, 32'h0);
    drive("R4 addr>pabt", 8'h08, 1, 32'h0400_0000, 32'h0);
    drive("R4 pabt>und", 8'h0A, 0, 32'h0, 32'h0);
    drive("R4 und>swi", 8'h06, 0, 32'h0, 32'h0);
    // R7 back-to-back then quiet
    drive("R7 again", 8'h04, 0, 32'h0, 32'h0000_0100);
    drive("R7 quiet", 8'h00, 0, 32'h0, 32'h0);
    drive("R7 quiet2", 8'h00, 0, 32'h0, 32'h0);
    @(posedge clk); #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule